// File: doc/BRIEF.md
# Reset Configuration Word Loader

This block is the master of the reset configuration phase. On the first clock after its synchronous reset is released, it reads a fixed table of configuration bytes from a boot memory. Four successive byte reads make one 32-bit word. The table holds eight words. Word 0 configures the local processor. Words 1 to 7 are handed, in order, to up to seven slave devices.

The loader always takes each byte from the most significant lane of the memory read bus. Each read address is a multiple of eight. Because of this, the port width of the boot device has no effect on the result. When the last byte arrives, the loader does three things: it raises a one-cycle completion pulse, it presents the master word, and it presents the reset fetch address. That address is the exception base selected by one prefix bit of the master word, plus 0x100.

The memory port uses a request/acknowledge handshake with one read outstanding. If a read waits too long for its acknowledge, the loader raises an error and stops.

Top module: `cfg_word_loader`

## Requirements
- R1: On the first rising edge with `rst` low after reset, the loader raises `mem_req` with `mem_addr` = 0.
- R2: Exactly 32 reads are issued. Read n uses address 8*n. `mem_addr` holds while a read is unacknowledged. A read completes on a rising edge where `mem_req` and `mem_ack` are both high, so with zero wait the reads come one per cycle.
- R3: Each read samples only `mem_rdata[DATA_W-1:DATA_W-8]`, the most significant byte lane. All other lanes are ignored.
- R4: Within each group of four reads, the first byte becomes bits 31:24 of the word and the fourth becomes bits 7:0.
- R5: Word 0 appears on `master_word`. `cfg_done` pulses high for exactly one cycle after the edge that captures the 32nd byte.
- R6: Words 1 to 7 appear on `slave_word` with `slave_idx` = 1..7 in ascending order. Each comes with a one-cycle `slave_valid`, registered on the edge that captures the word's fourth byte.
- R7: When `cfg_done` rises, `reset_vector` is 0xFFF00100 if bit 26 of the master word is 1, and 0x00000100 if it is 0.
- R8: If `ACK_TIMEOUT` consecutive request cycles pass without an acknowledge, `load_err` is set and `mem_req` drops. An acknowledge after `ACK_TIMEOUT-1` waiting cycles still completes normally.
- R9: A synchronous reset, even in the middle of a load, clears `mem_req`, `mem_addr`, `master_word`, `slave_word`, `slave_idx`, `slave_valid`, `cfg_done`, `reset_vector` and `load_err`.
- R10: After completion or an error, no further request is issued until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Read request to boot memory |
| mem_addr | output | ADDR_W | Byte address of the current read |
| mem_ack | input | 1 | Read acknowledge, with data valid |
| mem_rdata | input | DATA_W | Read data bus; only the top byte is used |
| master_word | output | 32 | Local configuration word (word 0) |
| slave_word | output | 32 | Configuration word for a slave |
| slave_idx | output | 3 | Slave position 1..7 of `slave_word` |
| slave_valid | output | 1 | One-cycle strobe for `slave_word`/`slave_idx` |
| cfg_done | output | 1 | One-cycle pulse when all words are loaded |
| reset_vector | output | ADDR_W | Exception base plus 0x100 |
| load_err | output | 1 | Sticky acknowledge-timeout flag |

## Verification
The bench builds the loader with a 64-bit data bus and `ACK_TIMEOUT` set to 8. This brings both sides of the timeout boundary within a few dozen cycles: a memory that waits seven cycles completes the load, and a memory that never answers read 5 trips the error after exactly eight waiting cycles. The lower data lanes always carry bytes that differ from the top lane, so sampling the wrong lane corrupts every word. The images set and clear the prefix bit, so both exception bases are selected.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_FETCH = 2'd1,
    LD_DONE  = 2'd2,
    LD_FAULT = 2'd3
  } ld_state_t;

  localparam logic [31:0] VEC_BASE_HIGH = 32'hFFF0_0000;
  localparam logic [31:0] VEC_BASE_LOW  = 32'h0000_0000;
  localparam logic [31:0] VEC_OFFSET    = 32'h0000_0100;
endpackage

// File: rtl/cwl_fetch_ctrl.sv
module cwl_fetch_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int NUM_READS   = 32,
  parameter int READ_STRIDE = 8,
  parameter int ACK_TIMEOUT = 256,
  localparam int CNT_W      = $clog2(NUM_READS),
  localparam int TO_W       = $clog2(ACK_TIMEOUT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              beat,
  output logic [CNT_W-1:0]  beat_idx,
  output logic              last_beat,
  output logic              load_err
);
  import cwl_pkg::*;

  ld_state_t        state;
  logic [TO_W-1:0]  wait_cnt;

  assign mem_req   = (state == LD_FETCH);
  assign beat      = mem_req && mem_ack;
  assign last_beat = beat && (beat_idx == CNT_W'(NUM_READS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= LD_IDLE;
      mem_addr <= '0;
      beat_idx <= '0;
      wait_cnt <= '0;
      load_err <= 1'b0;
    end else begin
      case (state)
        LD_IDLE: begin
          state    <= LD_FETCH;
          mem_addr <= '0;
          beat_idx <= '0;
          wait_cnt <= '0;
        end
        LD_FETCH: begin
          if (mem_ack) begin
            wait_cnt <= '0;
            if (beat_idx == CNT_W'(NUM_READS - 1)) begin
              state <= LD_DONE;
            end else begin
              beat_idx <= beat_idx + 1'b1;
              mem_addr <= mem_addr + ADDR_W'(READ_STRIDE);
            end
          end else if (wait_cnt == TO_W'(ACK_TIMEOUT - 1)) begin
            state    <= LD_FAULT;
            load_err <= 1'b1;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: state <= state;
      endcase
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> $stable(mem_addr)) else $error("addr moved"); // R2
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr % READ_STRIDE == 0)) else $error("addr align"); // R2
  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    load_err |-> !mem_req) else $error("req after error"); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    load_err |=> load_err) else $error("error cleared"); // R10
endmodule

// File: rtl/cwl_word_pack.sv
module cwl_word_pack #(
  parameter int NUM_WORDS      = 8,
  parameter int BYTES_PER_WORD = 4,
  localparam int WORD_W        = 8 * BYTES_PER_WORD,
  localparam int SEL_W         = $clog2(BYTES_PER_WORD),
  localparam int IDX_W         = $clog2(NUM_WORDS),
  localparam int CNT_W         = SEL_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat,
  input  logic [CNT_W-1:0]  beat_idx,
  input  logic [7:0]        byte_in,
  output logic [WORD_W-1:0] master_word,
  output logic [WORD_W-1:0] slave_word,
  output logic [IDX_W-1:0]  slave_idx,
  output logic              slave_valid
);
  logic [WORD_W-9:0]  partial;
  logic [WORD_W-1:0]  word_nx;
  logic [SEL_W-1:0]   byte_pos;
  logic [IDX_W-1:0]   word_pos;
  logic               word_end;

  assign word_nx  = {partial, byte_in};
  assign byte_pos = beat_idx[SEL_W-1:0];
  assign word_pos = beat_idx[CNT_W-1:SEL_W];
  assign word_end = beat && (byte_pos == SEL_W'(BYTES_PER_WORD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      partial     <= '0;
      master_word <= '0;
      slave_word  <= '0;
      slave_idx   <= '0;
      slave_valid <= 1'b0;
    end else begin
      slave_valid <= 1'b0;
      if (beat) begin
        partial <= word_nx[WORD_W-9:0];
      end
      if (word_end) begin
        if (word_pos == '0) begin
          master_word <= word_nx;
        end else begin
          slave_word  <= word_nx;
          slave_idx   <= word_pos;
          slave_valid <= 1'b1;
        end
      end
    end
  end

  AST_SLV_PULSE: assert property (@(posedge clk) disable iff (rst)
    slave_valid |=> !slave_valid) else $error("valid too long"); // R6
  AST_SLV_IDX: assert property (@(posedge clk) disable iff (rst)
    slave_valid |-> (slave_idx != '0)) else $error("slave idx zero"); // R6
endmodule

// File: rtl/cwl_boot_vec.sv
module cwl_boot_vec #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              prefix,
  output logic              cfg_done,
  output logic [ADDR_W-1:0] reset_vector
);
  import cwl_pkg::*;

  logic [ADDR_W-1:0] base_sel;
  assign base_sel = prefix ? ADDR_W'(VEC_BASE_HIGH) : ADDR_W'(VEC_BASE_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_done     <= 1'b0;
      reset_vector <= '0;
    end else begin
      cfg_done <= fire;
      if (fire) begin
        reset_vector <= base_sel + ADDR_W'(VEC_OFFSET);
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> !cfg_done) else $error("done too long"); // R5
  AST_VEC_OFFSET: assert property (@(posedge clk) disable iff (rst)
    cfg_done |-> (reset_vector[11:0] == 12'h100)) else $error("vector offset"); // R7
endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader #(
  parameter int ADDR_W         = 32,
  parameter int DATA_W         = 64,
  parameter int NUM_WORDS      = 8,
  parameter int BYTES_PER_WORD = 4,
  parameter int READ_STRIDE    = 8,
  parameter int ACK_TIMEOUT    = 256,
  parameter int PREFIX_BIT     = 26,
  localparam int WORD_W        = 8 * BYTES_PER_WORD,
  localparam int IDX_W         = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] master_word,
  output logic [WORD_W-1:0] slave_word,
  output logic [IDX_W-1:0]  slave_idx,
  output logic              slave_valid,
  output logic              cfg_done,
  output logic [ADDR_W-1:0] reset_vector,
  output logic              load_err
);
  localparam int NUM_READS = NUM_WORDS * BYTES_PER_WORD;
  localparam int CNT_W     = $clog2(NUM_READS);

  logic             beat;
  logic             last_beat;
  logic [CNT_W-1:0] beat_idx;
  logic [7:0]       lane_byte;

  // R3: the byte lane is always the most significant one
  generate
    if (DATA_W > 8) begin : g_wide_bus
      logic lanes_unused;
      assign lanes_unused = ^mem_rdata[DATA_W-9:0];
    end
  endgenerate
  assign lane_byte = mem_rdata[DATA_W-1 -: 8];

  cwl_fetch_ctrl #(
    .ADDR_W     (ADDR_W),
    .NUM_READS  (NUM_READS),
    .READ_STRIDE(READ_STRIDE),
    .ACK_TIMEOUT(ACK_TIMEOUT)
  ) fetch_i (
    .clk      (clk),
    .rst      (rst),
    .mem_ack  (mem_ack),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .beat     (beat),
    .beat_idx (beat_idx),
    .last_beat(last_beat),
    .load_err (load_err)
  );

  cwl_word_pack #(
    .NUM_WORDS     (NUM_WORDS),
    .BYTES_PER_WORD(BYTES_PER_WORD)
  ) pack_i (
    .clk        (clk),
    .rst        (rst),
    .beat       (beat),
    .beat_idx   (beat_idx),
    .byte_in    (lane_byte),
    .master_word(master_word),
    .slave_word (slave_word),
    .slave_idx  (slave_idx),
    .slave_valid(slave_valid)
  );

  cwl_boot_vec #(
    .ADDR_W(ADDR_W)
  ) vec_i (
    .clk         (clk),
    .rst         (rst),
    .fire        (last_beat),
    .prefix      (master_word[PREFIX_BIT]),
    .cfg_done    (cfg_done),
    .reset_vector(reset_vector)
  );

  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> !mem_req) else $error("req after done"); // R10
  AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
    cfg_done |-> !load_err) else $error("done with error"); // R8
endmodule

// File: tb/cfg_word_loader_tb_top.sv
module cfg_word_loader_tb_top;
  localparam int TO = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic [31:0] master_word, slave_word, reset_vector;
  logic [2:0]  slave_idx;
  logic        slave_valid, cfg_done, load_err;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  cfg_word_loader #(.ACK_TIMEOUT(TO)) dut_i (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .master_word(master_word),
    .slave_word(slave_word), .slave_idx(slave_idx), .slave_valid(slave_valid),
    .cfg_done(cfg_done), .reset_vector(reset_vector), .load_err(load_err)
  );

  // scenario table: ack delay, master word, expected reset vector
  localparam int NSCN = 4;
  localparam int          SCN_DLY   [NSCN] = '{0, 2, TO - 1, 1};
  localparam logic [31:0] SCN_MASTER[NSCN] = '{32'h1234_5678, 32'h04A5_5A01,
                                               32'hFBFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [31:0] SCN_VEC   [NSCN] = '{32'h0000_0100, 32'hFFF0_0100,
                                               32'h0000_0100, 32'hFFF0_0100};

  function automatic logic [31:0] img_word(int scn, int w);
    if (w == 0) return SCN_MASTER[scn];
    return (32'h1F2E_3D4C + 32'h0101_0101 * w) ^ (32'h00FF_00FF << scn);
  endfunction

  function automatic logic [7:0] img_byte(int scn, int rd);
    logic [31:0] w = img_word(scn, rd / 4);
    return w[31 - 8 * (rd % 4) -: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; mem_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(!mem_req && mem_addr == 0, "R9", {31'd0, mem_req}, 32'd0);
    chk(master_word == 0 && slave_word == 0 && slave_idx == 0, "R9", master_word, 32'd0);
    chk(!slave_valid && !cfg_done && !load_err, "R9",
        {29'd0, slave_valid, cfg_done, load_err}, 32'd0);
    chk(reset_vector == 0, "R9", reset_vector, 32'd0);
    rst = 1'b0;
  endtask

  // one load; stall_at >= 0 makes that read never acknowledged
  task automatic run_load(input int scn, input int dly, input int stall_at);
    int nrd = 0, wcnt = 0, exp_idx = 1, it = 0, stall_cyc = 0;
    bit done_seen = 0, err_seen = 0;
    logic [7:0] b;
    while (!done_seen && !err_seen && it < 3000) begin
      @(negedge clk);
      it++;
      if (it == 1) chk(mem_req && mem_addr == 0, "R1", mem_addr, 32'd0);
      if (slave_valid) begin
        chk(slave_idx == exp_idx[2:0], "R6", {29'd0, slave_idx}, exp_idx);
        chk(slave_word == img_word(scn, exp_idx), "R4", slave_word, img_word(scn, exp_idx));
        exp_idx++;
      end
      if (cfg_done) begin
        done_seen = 1;
        chk(stall_at < 0, "R8", 32'd1, 32'd0);
        chk(nrd == 32, "R2", nrd, 32'd32);
        chk(it == 32 * (dly + 1) + 1, "R2", it, 32 * (dly + 1) + 1);
        chk(exp_idx == 8, "R6", exp_idx, 32'd8);
        chk(master_word == img_word(scn, 0), "R5", master_word, img_word(scn, 0));
        chk(reset_vector == SCN_VEC[scn], "R7", reset_vector, SCN_VEC[scn]);
      end
      if (load_err) begin
        err_seen = 1;
        chk(stall_at >= 0, "R8", 32'd1, 32'd0);
        chk(stall_cyc == TO, "R8", stall_cyc, TO);
        chk(!mem_req, "R8", {31'd0, mem_req}, 32'd0);
      end
      mem_ack = 1'b0;
      mem_rdata = '0;
      if (mem_req && !done_seen && !err_seen) begin
        if (wcnt == 0) chk(mem_addr == 32'(8 * nrd), "R2", mem_addr, 32'(8 * nrd));
        chk(nrd < 32, "R10", nrd, 32'd31);
        if (nrd == stall_at) begin
          stall_cyc++;
        end else if (wcnt >= dly) begin
          b = img_byte(scn, nrd);
          mem_ack = 1'b1;
          mem_rdata = {b, {7{b ^ 8'hA5}}};  // R3: low lanes carry other bytes
          nrd++;
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end
    end
    chk(done_seen || err_seen, "watchdog", it, 32'd0);
    @(negedge clk);
    mem_ack = 1'b0;
    chk(!cfg_done, "R5", {31'd0, cfg_done}, 32'd0);
    repeat (4) begin
      @(negedge clk);
      chk(!mem_req && !slave_valid, "R10", {30'd0, mem_req, slave_valid}, 32'd0);
    end
    if (err_seen) chk(load_err && !cfg_done, "R8", {31'd0, load_err}, 32'd1);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    @(negedge clk);
    // table walk
    for (int s = 0; s < NSCN; s++) begin
      do_reset();
      run_load(s, SCN_DLY[s], -1);
    end
    // timeout: read 5 is never acknowledged
    do_reset();
    run_load(0, 0, 5);
    // mid-load reset clears captured state
    do_reset();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      mem_ack = mem_req;
      mem_rdata = {img_byte(1, i), 56'h0};
    end
    @(negedge clk);
    mem_ack = 1'b0;
    chk(master_word == img_word(1, 0), "R5", master_word, img_word(1, 0));
    do_reset();
    run_load(3, 0, -1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule